// File: doc/BRIEF.md
# Keyboard Reply Responder

This block plays the part of a keyboard that hangs off the transmit side of a serial channel. Each byte the host sends toward the keyboard arrives on a one-cycle valid/data strobe and is read as a command. Some commands produce a fixed multi-byte answer. Key events arrive separately as a 7-bit scancode with a press/release flag. Every byte headed back to the host, whether an answer or a key code, goes into a small circular byte queue. The host drains that queue one byte per read strobe, and each read also reports whether bytes remain.

Command decoding works as follows. The identify command and the two layout commands each discard whatever the queue holds and then write their answer, one byte per cycle. The LED command arms a one-shot flag, and the flag swallows the next command byte whatever its value. Lock-style toggle keys are folded, so that only every other press and every other release reaches the queue. The scancodes of the toggle keys are parameters.

Top module: `kbr_responder`

## Requirements
- R1: After synchronous reset the queue is empty (`data_avail` low), `rd_data` and `rd_more` are 0, the LED skip flag is clear and every toggle state is 0.
- R2: Command byte 0x01 empties the queue in the cycle it is taken and then writes 0xFF, 0x04, 0x7F in that order, one byte per following cycle.
- R3: Command bytes 0x07 and 0x0F empty the queue and then write 0xFE, 0x21 in that order.
- R4: Command byte 0x0E sets a skip flag. The next command byte, of any value, is discarded and clears the flag.
- R5: Every other command byte leaves the queue contents unchanged.
- R6: A key press writes the byte {0, scancode}. A key release writes {1, scancode}, so bit 7 marks a release.
- R7: Each toggle key keeps a 2-bit state that is XORed with 1 on a press and with 2 on a release. A press is dropped when the new state is 2, and a release is dropped when the new state is 3.
- R8: The queue holds DEPTH (16) bytes. A write while the queue holds DEPTH bytes is discarded, and the stored bytes stay as they were.
- R9: A read strobe on an empty queue returns 0 on `rd_data`, and `rd_more` is 0.
- R10: A read returns the oldest byte on `rd_data` in the cycle after the strobe. `rd_more` is then high exactly when bytes remain, and `data_avail` is high whenever the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a host command byte |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | One-cycle strobe for a key event |
| key_code | input | 7 | Scancode of the key event |
| key_release | input | 1 | 1 for a release, 0 for a press |
| pop | input | 1 | Read strobe: take one byte from the queue |
| rd_data | output | 8 | Byte taken by the last read, or 0 if that read found the queue empty |
| rd_more | output | 1 | Queue not empty after the last read |
| data_avail | output | 1 | Queue holds at least one byte |

## Verification
The command decoder is swept over all 256 byte values. Before each one, a key byte is placed in the queue. Flushing replies then show up as a missing key byte followed by the exact answer, and ignored commands show up as that key byte alone. Because the sweep passes through 0x0E, the following value (0x0F) must be swallowed, which separates the skip flag from ordinary decoding. Press and release of all 128 scancodes are sent in groups that fill the queue exactly, which checks bit-7 marking. Long alternating press/release runs on each toggle key separate the folding from plain key passing, and a 20-key burst with a draining empty read exercises the overflow and empty-queue edges.

// File: rtl/kbr_pkg.sv
package kbr_pkg;

    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 7;
    localparam int RPL_IDX_W = 2;

    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [CODE_W-1:0]    code_t;
    typedef logic [RPL_IDX_W-1:0] rpl_idx_t;
    typedef logic [1:0]           tog_t;

    typedef enum logic [1:0] {
        CMD_IGNORE,
        CMD_IDENT,
        CMD_LAYOUT,
        CMD_LEDS
    } cmd_kind_e;

    typedef enum logic {
        RPL_IDENT,
        RPL_LAYOUT
    } reply_e;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } push_t;

    typedef struct packed {
        logic  valid;
        logic  rel;
        code_t code;
    } key_evt_t;

    function automatic cmd_kind_e classify(input byte_t c);
        case (c)
            8'h01:        return CMD_IDENT;
            8'h07, 8'h0F: return CMD_LAYOUT;
            8'h0E:        return CMD_LEDS;
            default:      return CMD_IGNORE;
        endcase
    endfunction

    function automatic rpl_idx_t reply_last(input reply_e k);
        return (k == RPL_IDENT) ? rpl_idx_t'(2) : rpl_idx_t'(1);
    endfunction

    function automatic byte_t reply_byte(input reply_e k, input rpl_idx_t idx);
        if (k == RPL_IDENT) begin
            case (idx)
                2'd0:    return 8'hFF;
                2'd1:    return 8'h04;
                default: return 8'h7F;
            endcase
        end
        return (idx == 2'd0) ? 8'hFE : 8'h21;
    endfunction

    function automatic tog_t toggle_next(input tog_t s, input logic rel);
        return rel ? (s ^ 2'd2) : (s ^ 2'd1);
    endfunction

    function automatic logic toggle_pass(input tog_t ns, input logic rel);
        return rel ? (ns != 2'd3) : (ns != 2'd2);
    endfunction

    function automatic byte_t key_byte(input logic rel, input code_t code);
        return {rel, code};
    endfunction

endpackage

// File: rtl/kbr_fifo.sv
module kbr_fifo
    import kbr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  push_t push,
    input  logic  pop,
    output byte_t rd_data,
    output logic  rd_more,
    output logic  avail
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    byte_t             mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic              can_push, can_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        can_pop  = pop && (cnt_q != '0);
        can_push = push.valid && !flush && (cnt_q != FULL_CNT);
        if (flush)
            cnt_nx = '0;
        else
            cnt_nx = cnt_q + CNT_W'(can_push) - CNT_W'(can_pop);
    end

    always_ff @(posedge clk) begin
        if (can_push)
            mem[wr_q] <= push.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            rd_q    <= '0;
            cnt_q   <= '0;
            rd_data <= '0;
            rd_more <= 1'b0;
        end else begin
            if (pop) begin
                rd_data <= can_pop ? mem[rd_q] : '0;
                rd_more <= (cnt_nx != '0);
            end
            if (flush) begin
                wr_q <= '0;
                rd_q <= '0;
            end else begin
                if (can_push) wr_q <= ptr_inc(wr_q);
                if (can_pop)  rd_q <= ptr_inc(rd_q);
            end
            cnt_q <= cnt_nx;
        end
    end

    assign avail = (cnt_q != '0);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL_CNT && push.valid && !pop && !flush)
            |=> (cnt_q == FULL_CNT) && $stable(wr_q) && $stable(rd_q));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt_q == '0 && !push.valid) |=> (rd_data == '0) && !rd_more);

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

endmodule

// File: rtl/kbr_cmd_seq.sv
module kbr_cmd_seq
    import kbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  byte_t cmd_byte,
    output logic  flush,
    output push_t push,
    output logic  busy
);
    logic      skip_q;
    logic      active_q;
    reply_e    kind_q;
    rpl_idx_t  idx_q;
    cmd_kind_e kind_now;
    logic      take_reply;

    always_comb begin
        kind_now   = classify(cmd_byte);
        take_reply = cmd_valid && !skip_q &&
                     (kind_now == CMD_IDENT || kind_now == CMD_LAYOUT);
        flush      = take_reply;
        push.valid = active_q && !take_reply;
        push.data  = reply_byte(kind_q, idx_q);
        busy       = active_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q   <= 1'b0;
            active_q <= 1'b0;
            kind_q   <= RPL_IDENT;
            idx_q    <= '0;
        end else begin
            if (cmd_valid) begin
                if (skip_q)
                    skip_q <= 1'b0;
                else if (kind_now == CMD_LEDS)
                    skip_q <= 1'b1;
            end
            if (take_reply) begin
                active_q <= 1'b1;
                kind_q   <= (kind_now == CMD_IDENT) ? RPL_IDENT : RPL_LAYOUT;
                idx_q    <= '0;
            end else if (active_q) begin
                if (idx_q == reply_last(kind_q)) begin
                    active_q <= 1'b0;
                    idx_q    <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    p_skip_once_r4: assert property (@(posedge clk) disable iff (rst)
        (skip_q && cmd_valid) |=> !skip_q && !$rose(active_q));

    p_reply_index_r2: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (idx_q <= reply_last(kind_q)));

endmodule

// File: rtl/kbr_key_fold.sv
module kbr_key_fold
    import kbr_pkg::*;
#(
    parameter int                          N_LOCKS    = 2,
    parameter logic [N_LOCKS*CODE_W-1:0]   LOCK_CODES = {7'h62, 7'h77}
) (
    input  logic     clk,
    input  logic     rst,
    input  key_evt_t evt,
    output push_t    push
);
    logic [N_LOCKS-1:0][1:0] tog_q;
    logic [N_LOCKS-1:0][1:0] tog_nx;
    logic [N_LOCKS-1:0]      hit;
    logic [N_LOCKS-1:0]      veto;

    for (genvar g = 0; g < N_LOCKS; g++) begin : g_lock
        assign hit[g]    = evt.valid && (evt.code == LOCK_CODES[g*CODE_W +: CODE_W]);
        assign tog_nx[g] = toggle_next(tog_q[g], evt.rel);
        assign veto[g]   = hit[g] && !toggle_pass(tog_nx[g], evt.rel);

        p_toggle_step_r7: assert property (@(posedge clk) disable iff (rst)
            hit[g] |=> tog_q[g] == ($past(tog_q[g]) ^ ($past(evt.rel) ? 2'd2 : 2'd1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= '0;
        end else begin
            for (int i = 0; i < N_LOCKS; i++)
                if (hit[i]) tog_q[i] <= tog_nx[i];
        end
    end

    always_comb begin
        push.valid = evt.valid && (veto == '0);
        push.data  = key_byte(evt.rel, evt.code);
    end

endmodule

// File: rtl/kbr_responder.sv
module kbr_responder
    import kbr_pkg::*;
#(
    parameter int                        DEPTH      = 16,
    parameter int                        N_LOCKS    = 2,
    parameter logic [N_LOCKS*CODE_W-1:0] LOCK_CODES = {7'h62, 7'h77}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       key_valid,
    input  logic [6:0] key_code,
    input  logic       key_release,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       rd_more,
    output logic       data_avail
);
    logic     seq_flush, seq_busy;
    push_t    seq_push, key_push, q_push;
    key_evt_t evt;

    assign evt = '{valid: key_valid, rel: key_release, code: key_code};

    kbr_cmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .flush     (seq_flush),
        .push      (seq_push),
        .busy      (seq_busy)
    );

    kbr_key_fold #(
        .N_LOCKS    (N_LOCKS),
        .LOCK_CODES (LOCK_CODES)
    ) u_keys (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .push (key_push)
    );

    always_comb begin
        if (seq_push.valid)
            q_push = seq_push;
        else if (key_push.valid && !seq_busy && !seq_flush)
            q_push = key_push;
        else
            q_push = '0;
    end

    kbr_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (seq_flush),
        .push    (q_push),
        .pop     (pop),
        .rd_data (rd_data),
        .rd_more (rd_more),
        .avail   (data_avail)
    );

    // R3 shares this flush path with R2
    p_flush_empties_r2: assert property (@(posedge clk) disable iff (rst)
        seq_flush |=> !data_avail);

endmodule

// File: tb/kbr_responder_tb_top.sv
module kbr_responder_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, key_valid, key_release, pop;
    logic [7:0] cmd_byte;
    logic [6:0] key_code;
    logic [7:0] rd_data;
    logic       rd_more, data_avail;

    localparam logic [6:0] LOCK0 = 7'h77;
    localparam logic [6:0] LOCK1 = 7'h62;
    localparam int         QD    = 16;

    always #4 clk = ~clk;

    kbr_responder dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .key_valid(key_valid), .key_code(key_code), .key_release(key_release),
        .pop(pop), .rd_data(rd_data), .rd_more(rd_more), .data_avail(data_avail)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] mq[$];
    logic       m_skip;
    logic [1:0] m_tog[2];

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic m_push(input logic [7:0] b);
        if (mq.size() < QD) mq.push_back(b);
    endtask

    task automatic m_cmd(input logic [7:0] c);
        if (m_skip) m_skip = 1'b0;
        else if (c == 8'h01) begin mq.delete(); m_push(8'hFF); m_push(8'h04); m_push(8'h7F); end
        else if (c == 8'h07 || c == 8'h0F) begin mq.delete(); m_push(8'hFE); m_push(8'h21); end
        else if (c == 8'h0E) m_skip = 1'b1;
    endtask

    task automatic m_key(input logic [6:0] code, input logic rel);
        logic pass = 1'b1;
        for (int i = 0; i < 2; i++) begin
            if (code == (i == 0 ? LOCK0 : LOCK1)) begin
                m_tog[i] = m_tog[i] ^ (rel ? 2'd2 : 2'd1);
                pass = rel ? (m_tog[i] != 2'd3) : (m_tog[i] != 2'd2);
            end
        end
        if (pass) m_push({rel, code});
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        m_cmd(c);
    endtask

    task automatic send_key(input logic [6:0] code, input logic rel);
        @(negedge clk);
        key_valid = 1'b1; key_code = code; key_release = rel;
        @(negedge clk);
        key_valid = 1'b0;
        m_key(code, rel);
    endtask

    task automatic drain(input string tag);
        @(negedge clk);
        check(data_avail == (mq.size() != 0), {tag, " R10 avail"}, data_avail, mq.size() != 0);
        while (mq.size() > 0) begin
            logic [7:0] e;
            e = mq.pop_front();
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
            check(rd_data == e, {tag, " R10 data"}, rd_data, e);
            check(rd_more == (mq.size() != 0), {tag, " R10 more"}, rd_more, mq.size() != 0);
        end
        check(data_avail == 1'b0, {tag, " R10 empty"}, data_avail, 0);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check(rd_data == 8'h00 && !rd_more, {tag, " R9 empty read"}, {rd_more, rd_data}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_byte = '0; key_valid = 1'b0;
        key_code = '0; key_release = 1'b0; pop = 1'b0;
        m_skip = 1'b0; m_tog[0] = 2'd0; m_tog[1] = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!data_avail && rd_data == 0 && !rd_more, "R1 reset", {data_avail, rd_more, rd_data}, 0);
        drain("R1");

        // R2 R3 R4 R5: every command value with one key byte queued first
        for (int v = 0; v < 256; v++) begin
            send_key(7'h11, 1'b0);
            send_cmd(8'(v));
            drain("R2 R3 R4 R5 sweep");
        end

        // R4: the skipped byte may be a reply command
        send_cmd(8'h0E);
        send_cmd(8'h01);
        drain("R4 skip");
        send_cmd(8'h01);
        drain("R4 after skip");

        // R6: all scancodes, press then release, 16 bytes per group
        for (int g = 0; g < 16; g++) begin
            for (int k = 0; k < 8; k++) begin
                send_key(7'(g * 8 + k), 1'b0);
                send_key(7'(g * 8 + k), 1'b1);
            end
            drain("R6 keys");
        end

        // R7: toggle folding on each lock key
        for (int r = 0; r < 6; r++) begin
            send_key(LOCK0, 1'b0); send_key(LOCK0, 1'b1);
            send_key(LOCK1, 1'b0); send_key(LOCK1, 1'b1);
        end
        drain("R7 toggles");
        send_key(LOCK0, 1'b0); send_key(LOCK0, 1'b0); send_key(LOCK0, 1'b1);
        send_key(LOCK0, 1'b1); send_key(LOCK0, 1'b1);
        drain("R7 irregular");

        // R8: burst past the queue depth
        for (int i = 0; i < 20; i++) send_key(7'(8'h20 + i), 1'b0);
        @(negedge clk);
        check(mq.size() == QD, "R8 model depth", mq.size(), QD);
        drain("R8 overflow");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule